// File: doc/BRIEF.md
# Flash page program buffer

This block gathers the data bytes of a page-program command into a one-page staging buffer and then commits them to a flash array model. A command start pulse supplies the target address. The page index is kept, and the low address bits seed a byte offset that steps up by one for each received byte. When the offset passes the end of the page it returns to zero, so bytes beyond one page overwrite the bytes taken earlier at the same offset.

The commit happens on a chip-select rise, and only when four conditions all hold: the rise came on a byte boundary, the write-enable latch is set, the page is not locked by the protection level, and at least one byte arrived. A commit emits a one-cycle program request carrying the page, a per-byte mask and the buffered data. The array then clears bits (new byte = old byte AND data) in the masked bytes only. Busy stays high for a time proportional to the number of bytes received, and a single-cycle pulse tells the status logic to drop the write-enable latch once the cycle is over. Any other chip-select rise discards the buffer without programming and without setting busy.

Top module: `page_prog_buf`

## Requirements
- R1: A `cmd_start_i` pulse while idle latches the page from the upper address bits and the start offset from the low log2(PAGE_BYTES) bits. The k-th received byte is stored at start offset + k.
- R2: The offset wraps from PAGE_BYTES-1 to 0 within the same page. A later byte for an offset replaces the earlier one, and `prog_mask_o` has a 1 for every offset received.
- R3: Array bytes whose offset was not received, and all bytes of other pages, keep their values after a program.
- R4: Programming only clears bits: each masked array byte becomes old value AND buffered data. The array resets to 8'hFF.
- R5: A chip-select rise with `cs_aligned_i` low discards the command: no program request and no busy.
- R6: A chip-select rise with `wel_i` low discards the command.
- R7: A command to a locked page is discarded. For `prot_level_i` = L, level 0 locks nothing, and L >= 1 locks the top min(2^(L-1), NUM_PAGES) pages (the highest page indices).
- R8: After a commit, `busy_o` is high for exactly n*BYTE_CYCLES cycles, starting the cycle after the committing edge. n is the number of bytes received, capped at PAGE_BYTES. `prog_valid_o` is a one-cycle pulse in the first busy cycle.
- R9: `wel_clr_o` pulses for one cycle, in the first cycle after busy falls.
- R10: While `busy_o` is high, `cmd_start_i`, `byte_valid_i` and `cs_rise_i` have no effect on the array or on busy.
- R11: A byte presented in the same cycle as the chip-select rise is included in the committed page and in n.
- R12: A chip-select rise with no byte received programs nothing and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Program command decoded, address valid |
| start_addr_i | input | ADDR_W | Start byte address |
| byte_valid_i | input | 1 | Received data byte strobe |
| byte_data_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select deasserted this cycle |
| cs_aligned_i | input | 1 | The chip-select rise fell on a byte boundary |
| wel_i | input | 1 | Write-enable latch state |
| prot_level_i | input | LVL_W | Protection level |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |
| prog_valid_o | output | 1 | Program request pulse |
| prog_page_o | output | PAGE_W | Program request page |
| prog_mask_o | output | PAGE_BYTES | Per-byte write mask |
| prog_data_o | output | PAGE_BYTES*8 | Buffered page data, byte i at bits 8i+7:8i |
| busy_o | output | 1 | Program cycle in progress |
| wel_clr_o | output | 1 | Clear the write-enable latch |

## Verification
The last data byte and the chip-select rise can arrive in the same cycle. The bench provokes this by raising `cs_rise_i` together with the final `byte_valid_i`, both for a short command and for one that has already wrapped. It then judges the result three ways: `prog_mask_o` must include that final offset, the busy length must count it, and the array must hold it ANDed in. A second collision is a new command and new bytes arriving in the first busy cycle, while the request pulse is still high. This must leave the array exactly as the reference model predicts.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;
  typedef logic [7:0] byte_t;

  // pages locked at the top of the array for a protection level
  function automatic int lock_span(int lvl, int page_w, int num_pages);
    if (lvl == 0) return 0;
    if (lvl - 1 >= page_w) return num_pages;
    return 1 << (lvl - 1);
  endfunction
endpackage

// File: rtl/ppb_lock.sv
`timescale 1ns/1ps
module ppb_lock #(
  parameter int NUM_PAGES = 4,
  parameter int PAGE_W    = 2,
  parameter int LVL_W     = 3
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              locked_o
);
  int span;
  always_comb begin
    span     = ppb_pkg::lock_span(int'(level_i), PAGE_W, NUM_PAGES);
    locked_o = (int'(page_i) >= NUM_PAGES - span);
  end
endmodule

// File: rtl/ppb_fill.sv
`timescale 1ns/1ps
module ppb_fill #(
  parameter  int PAGE_BYTES = 256,
  parameter  int PAGE_W     = 2,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1),
  localparam int ADDR_W     = OFF_W + PAGE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    busy_i,
  input  logic                    cmd_start_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_data_i,
  input  logic                    cs_rise_i,
  input  logic                    cs_aligned_i,
  input  logic                    wel_i,
  input  logic                    locked_i,
  output logic [PAGE_W-1:0]       page_o,
  output logic                    prog_valid_o,
  output logic [PAGE_BYTES-1:0]   mask_o,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic [CNT_W-1:0]        nbytes_o
);
  import ppb_pkg::*;

  logic                  active_q, pv_q;
  logic [PAGE_W-1:0]     page_q;
  logic [OFF_W-1:0]      off_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PAGE_BYTES-1:0] mask_q;
  byte_t                 data_q [PAGE_BYTES];

  logic start_in, byte_in, have_bytes, commit;

  assign start_in   = cmd_start_i & ~busy_i;
  assign byte_in    = byte_valid_i & active_q & ~start_in;
  assign have_bytes = (cnt_q != '0) | byte_in;
  assign commit     = cs_rise_i & active_q & ~start_in & cs_aligned_i & wel_i
                    & ~locked_i & have_bytes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pv_q     <= 1'b0;
      page_q   <= '0;
      off_q    <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else begin
      pv_q <= commit;
      if (start_in) begin
        active_q <= 1'b1;
        page_q   <= start_addr_i[ADDR_W-1:OFF_W];
        off_q    <= start_addr_i[OFF_W-1:0];
        cnt_q    <= '0;
        mask_q   <= '0;
      end else begin
        if (byte_in) begin
          mask_q[off_q] <= 1'b1;
          off_q         <= off_q + 1'b1;   // wraps inside the page
          if (cnt_q != CNT_W'(PAGE_BYTES)) cnt_q <= cnt_q + 1'b1;
        end
        if (cs_rise_i) active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_in) data_q[off_q] <= byte_data_i;
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_data
    assign data_o[i*8 +: 8] = data_q[i];
  end

  assign page_o       = page_q;
  assign prog_valid_o = pv_q;
  assign mask_o       = mask_q;
  assign nbytes_o     = cnt_q;

  // R2
  wrap_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_in && !start_in && off_q == OFF_W'(PAGE_BYTES - 1) |=> off_q == '0);
  // R5
  unaligned_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && active_q && !cs_aligned_i |=> !prog_valid_o);
  // R6
  no_wel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && !wel_i |=> !prog_valid_o);
  // R7
  locked_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && locked_i |=> !prog_valid_o);
  // R12
  empty_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && cnt_q == '0 && !byte_valid_i |=> !prog_valid_o);
  // R10
  busy_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !active_q |=> !active_q);
  // R8
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |=> !prog_valid_o);
endmodule

// File: rtl/ppb_timer.sv
`timescale 1ns/1ps
module ppb_timer #(
  parameter  int PAGE_BYTES  = 256,
  parameter  int BYTE_CYCLES = 3,
  localparam int CNT_W       = $clog2(PAGE_BYTES + 1),
  localparam int TM_W        = $clog2(PAGE_BYTES * BYTE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [TM_W-1:0] span, tm_q;
  logic            done_q;

  assign span = TM_W'(nbytes_i) * TM_W'(BYTE_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (load_i)           tm_q <= span - 1'b1;  // load cycle is the first busy cycle
      else if (tm_q != '0)  tm_q <= tm_q - 1'b1;
      done_q <= load_i ? (span == TM_W'(1)) : (tm_q == TM_W'(1));
    end
  end

  assign busy_o = load_i | (tm_q != '0);
  assign done_o = done_q;

  // R9
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_q);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
endmodule

// File: rtl/ppb_array.sv
`timescale 1ns/1ps
module ppb_array #(
  parameter  int PAGE_BYTES = 256,
  parameter  int NUM_PAGES  = 4,
  parameter  int PAGE_W     = 2,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int ADDR_W     = OFF_W + PAGE_W,
  localparam int CELLS      = PAGE_BYTES * NUM_PAGES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    prog_valid_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o
);
  import ppb_pkg::*;

  logic [CELLS*8-1:0] flat;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    byte_t cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cell_q <= 8'hFF;
      else if (prog_valid_i && page_i == PAGE_W'(g / PAGE_BYTES) && mask_i[g % PAGE_BYTES])
        cell_q <= cell_q & data_i[(g % PAGE_BYTES)*8 +: 8];
    end
    assign flat[g*8 +: 8] = cell_q;
  end

  assign rd_data_o = flat[{rd_addr_i, 3'b000} +: 8];

  // R4
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_addr_i) |-> (rd_data_o & ~$past(rd_data_o)) == 8'h00);
endmodule

// File: rtl/page_prog_buf.sv
`timescale 1ns/1ps
module page_prog_buf #(
  parameter  int PAGE_BYTES  = 256,
  parameter  int NUM_PAGES   = 4,
  parameter  int BYTE_CYCLES = 3,
  parameter  int LVL_W       = 3,
  localparam int PAGE_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int ADDR_W      = OFF_W + PAGE_W,
  localparam int CNT_W       = $clog2(PAGE_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_start_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_data_i,
  input  logic                    cs_rise_i,
  input  logic                    cs_aligned_i,
  input  logic                    wel_i,
  input  logic [LVL_W-1:0]        prot_level_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic                    prog_valid_o,
  output logic [PAGE_W-1:0]       prog_page_o,
  output logic [PAGE_BYTES-1:0]   prog_mask_o,
  output logic [PAGE_BYTES*8-1:0] prog_data_o,
  output logic                    busy_o,
  output logic                    wel_clr_o
);
  logic [PAGE_W-1:0] page;
  logic              locked, pv;
  logic [CNT_W-1:0]  nbytes;

  ppb_lock #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .LVL_W(LVL_W)) i_lock (
    .page_i   (page),
    .level_i  (prot_level_i),
    .locked_o (locked)
  );

  ppb_fill #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W)) i_fill (
    .clk_i, .rst_ni,
    .busy_i       (busy_o),
    .cmd_start_i, .start_addr_i, .byte_valid_i, .byte_data_i,
    .cs_rise_i, .cs_aligned_i, .wel_i,
    .locked_i     (locked),
    .page_o       (page),
    .prog_valid_o (pv),
    .mask_o       (prog_mask_o),
    .data_o       (prog_data_o),
    .nbytes_o     (nbytes)
  );

  ppb_timer #(.PAGE_BYTES(PAGE_BYTES), .BYTE_CYCLES(BYTE_CYCLES)) i_timer (
    .clk_i, .rst_ni,
    .load_i   (pv),
    .nbytes_i (nbytes),
    .busy_o   (busy_o),
    .done_o   (wel_clr_o)
  );

  ppb_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) i_array (
    .clk_i, .rst_ni,
    .prog_valid_i (pv),
    .page_i       (page),
    .mask_i       (prog_mask_o),
    .data_i       (prog_data_o),
    .rd_addr_i, .rd_data_o
  );

  assign prog_valid_o = pv;
  assign prog_page_o  = page;

  // R8
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> busy_o);
  // R9
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wel_clr_o);
endmodule

// File: tb/test_page_prog_buf.sv
`timescale 1ns/1ps
module test_page_prog_buf;
  localparam int PB = 16;
  localparam int NP = 4;
  localparam int BC = 3;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, byte_valid = 0, cs_rise = 0, cs_aligned = 0, wel = 0;
  logic [AW-1:0] start_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0, rd_data;
  logic [2:0] prot = '0;
  logic prog_valid, busy, wel_clr;
  logic [1:0] prog_page;
  logic [PB-1:0] prog_mask;
  logic [PB*8-1:0] prog_data;

  int errors = 0, checks = 0;
  logic [7:0] ref_mem [NP*PB];

  always #2 clk = ~clk;

  page_prog_buf #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .BYTE_CYCLES(BC), .LVL_W(3)) i_page_prog_buf (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .start_addr_i(start_addr),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .cs_rise_i(cs_rise),
    .cs_aligned_i(cs_aligned), .wel_i(wel), .prot_level_i(prot), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .prog_valid_o(prog_valid), .prog_page_o(prog_page),
    .prog_mask_o(prog_mask), .prog_data_o(prog_data), .busy_o(busy), .wel_clr_o(wel_clr));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1, fa = 0, fe = 0;
    for (int a = 0; a < NP*PB; a++) begin
      rd_addr = AW'(a);
      #0.1;
      if (rd_data !== ref_mem[a]) begin
        bad++;
        if (first < 0) begin first = a; fa = int'(rd_data); fe = int'(ref_mem[a]); end
      end
    end
    check(bad == 0, req, $sformatf("array byte %0d", first), fa, fe);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return ~(8'h01 << ((seed + i) % 8)) & ~(8'((seed * 7 + i * 3) & 8'h11));
  endfunction

  task automatic prog(input int page, input int off, input int n, input int seed,
                      input bit aligned, input bit we, input int lvl,
                      input bit merge, input bit intrude, input string req);
    int span, nexp, k;
    bit locked, commit;
    logic [PB-1:0] bm;
    logic [7:0] bd [PB];
    span   = (lvl == 0) ? 0 : ((lvl - 1 >= 2) ? NP : (1 << (lvl - 1)));
    locked = (page >= NP - span);
    commit = aligned && we && !locked && (n > 0);
    bm = '0;
    for (int i = 0; i < PB; i++) bd[i] = 8'h00;
    for (int i = 0; i < n; i++) begin
      bm[(off + i) % PB] = 1'b1;
      bd[(off + i) % PB] = pat(seed, i);
    end
    nexp = ((n > PB) ? PB : n) * BC;

    @(negedge clk);
    wel = we; prot = 3'(lvl);
    cmd_start = 1; start_addr = AW'(page * PB + off);
    @(negedge clk);
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = pat(seed, i);
      if (merge && i == n - 1) begin cs_rise = 1; cs_aligned = aligned; end
      @(negedge clk);
      byte_valid = 0;
    end
    if (!(merge && n > 0)) begin
      cs_rise = 1; cs_aligned = aligned;
      @(negedge clk);
    end
    cs_rise = 0; cs_aligned = 0;

    check(prog_valid == commit, req, "program request", int'(prog_valid), int'(commit));
    if (commit)
      check(prog_mask == bm && int'(prog_page) == page, req, "mask", int'(prog_mask), int'(bm));
    k = 0;
    while (busy && k < 5000) begin
      if (intrude) begin
        case (k)
          0: begin cmd_start = 1; start_addr = AW'(((page + 1) % NP) * PB); end
          1: begin cmd_start = 0; byte_valid = 1; byte_data = 8'h00; end
          4: begin byte_valid = 0; cs_rise = 1; cs_aligned = 1; end
          5: begin cs_rise = 0; cs_aligned = 0; end
          default: ;
        endcase
      end
      k++;
      @(negedge clk);
    end
    check(k == (commit ? nexp : 0), req, "busy length", k, commit ? nexp : 0);
    check(wel_clr == commit, req, "write-enable clear pulse", int'(wel_clr), int'(commit));
    @(negedge clk);
    check(!wel_clr && !busy, req, "quiet after cycle", int'({busy, wel_clr}), 0);
    if (commit)
      for (int o = 0; o < PB; o++)
        if (bm[o]) ref_mem[page*PB + o] = ref_mem[page*PB + o] & bd[o];
    check_mem(req);
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < NP*PB; a++) ref_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, R4 erased array
    check(!busy && !wel_clr && !prog_valid, "R8", "reset outputs", int'({busy, wel_clr, prog_valid}), 0);
    check_mem("R4");

    // R1 R2 R3 R4 R8 R9: offsets, lengths (incl. wrap) on every page
    foreach (ref_mem[s]) ;
    for (int p = 0; p < NP; p++)
      for (int oi = 0; oi < 3; oi++)
        for (int ni = 0; ni < 4; ni++) begin
          int offs [3] = '{0, 9, 15};
          int ns   [4] = '{1, 6, 16, 21};
          prog(p, offs[oi], ns[ni], p*12 + oi*4 + ni, 1, 1, 0, 0, 0,
               ns[ni] > PB ? "R2" : "R1");
        end
    // R5 unaligned chip-select rise
    prog(1, 2, 4, 3, 0, 1, 0, 0, 0, "R5");
    // R6 write enable clear
    prog(2, 7, 5, 5, 1, 0, 0, 0, 0, "R6");
    // R7 protection levels over all pages
    for (int l = 1; l <= 4; l++)
      for (int p = 0; p < NP; p++)
        prog(p, (l * 3 + p) % PB, 2, l + p, 1, 1, l, 0, 0, "R7");
    // R11 last byte with chip-select rise
    prog(0, 4, 5, 9, 1, 1, 0, 1, 0, "R11");
    prog(3, 14, 17, 2, 1, 1, 0, 1, 0, "R11");
    prog(1, 0, 1, 6, 1, 1, 0, 1, 0, "R11");
    // R10 command and bytes during busy
    prog(2, 1, 8, 11, 1, 1, 0, 0, 1, "R10");
    // R12 no data bytes
    prog(2, 5, 0, 0, 1, 1, 0, 0, 0, "R12");
    // R3 R4 final sweep with a fresh pattern
    prog(3, 3, 3, 1, 1, 1, 0, 0, 0, "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule